// File: doc/BRIEF.md
# SIMO Converter Switching-Path Sequencer

This block is the digital controller of a single-inductor, multi-output DC-DC converter. Once per switching cycle it chooses which power-switch path the inductor current takes and which output switch is closed. A cycle opens on the rising edge of a slow cycle clock and runs four phases in a fixed order. The first phase charges the buck outputs while the inductor is charging. A top-up phase then raises the inductor current to the peak level. A boost phase follows, and the inductor freewheels until the next cycle begins. The comparator flags that end each phase come from analog circuits outside this block.

A mode flag from an external power-comparison unit is sampled at the start of every cycle. While the flag is high the converter runs normal PWM sequencing. While it is low the buck phase is replaced by a direct-supply path that bypasses the inductor. This hysteresis operation keeps charge from piling up in the inductor when the buck loads draw more than the boost loads.

The path selects are one-hot. Every change of path passes through a programmable dead-time gap in which all selects are low. If the cycle clock falls before the boost phase has finished, the cycle is aborted to freewheeling and a sticky overrun bit is set.

Top module: `simo_path_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in freewheeling (`path_sel` = 5'b00001), clears `buck_en` and `boost_en`, sets PWM mode (`hyst_mode` = 0) and clears `overrun`.
- R2: A cycle starts at the first clock edge where `cyc_clk` is sampled high after being sampled low, and only while the block is freewheeling. That edge leaves the freewheel path for the buck phase (or for the direct path under R7).
- R3: In the buck phase, outputs are served one at a time in ascending index order. `buck_en[i]` alone is high for at least one clock and stays high until `buck_flag[i]` is sampled low; the phase ends when the highest-index output's flag is sampled low.
- R4: If `peak_trip` is low when the buck phase ends, the block enters the top-up path (`path_sel` bit 3) and stays there until `peak_trip` is sampled high.
- R5: If `peak_trip` is high when the buck phase ends, the top-up path is skipped and the boost phase follows directly.
- R6: The boost phase (`path_sel` bit 4) serves the boost outputs in ascending index order, with the same per-output rule as R3 applied to `boost_flag`. It is followed by the freewheel path, which is held until the next cycle starts.
- R7: `pwr_ok` is sampled at cycle start. If it is low, `hyst_mode` becomes 1 and the buck phase uses the direct-supply path (`path_sel` bit 2) instead of the inductor buck path (bit 1). `hyst_mode` holds its value until the next cycle start, where a high `pwr_ok` returns it to 0.
- R8: `path_sel` has at most one bit set. It is all zero only during a dead-time gap.
- R9: Every change of path inserts exactly `dead_len` clocks with all selects and all enables low. When `dead_len` is 0 the change takes effect at once.
- R10: A falling edge of `cyc_clk` seen in the buck, direct, top-up or boost phase, or during a gap leading to one of them, ends the cycle in freewheeling and sets `overrun`. `overrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_clk | input | 1 | Switching-cycle clock (about 90% high) |
| buck_flag | input | NUM_BUCK | Per-buck-output comparator flag; low ends that output's service |
| boost_flag | input | NUM_BOOST | Per-boost-output comparator flag; low ends that output's service |
| peak_trip | input | 1 | High when the inductor current has reached the peak level |
| pwr_ok | input | 1 | Mode flag from the power comparison; low requests hysteresis mode |
| dead_len | input | DT_W | Dead-time gap length in clocks |
| path_sel | output | 5 | One-hot path select: bit0 freewheel, bit1 buck, bit2 direct, bit3 top-up, bit4 boost |
| buck_en | output | NUM_BUCK | Buck output switch enables |
| boost_en | output | NUM_BOOST | Boost output switch enables |
| hyst_mode | output | 1 | 1 while in hysteresis mode |
| overrun | output | 1 | Sticky cycle-overrun status |

## Verification
Every output of the block is decoded from registers, so the response to inputs sampled at one rising edge is visible one clock later. This holds for a phase change, an output hand-over, a mode change and the overrun bit. The only longer latency is a dead-time gap, which delays the new path by exactly `dead_len` further clocks. The bench changes its stimulus on the falling edge and queues the value expected one rising edge later. It compares 1 ns after that edge, so each expectation lines up with a single register stage and the gap lengths are counted edge by edge.

// File: rtl/simo_seq_pkg.sv
// Package: shared state encoding and path decoding for the SIMO path sequencer.
// Assumes a single controller clock; path bit positions are fixed and decoded
// by the gate drivers downstream.
package simo_seq_pkg;

    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_DEAD   = 3'd1,
        ST_BUCK   = 3'd2,
        ST_DIRECT = 3'd3,
        ST_TOPUP  = 3'd4,
        ST_BOOST  = 3'd5
    } seq_state_t;

    localparam int PATH_N      = 5;
    localparam int PATH_FREE   = 0;
    localparam int PATH_BUCK   = 1;
    localparam int PATH_DIRECT = 2;
    localparam int PATH_TOPUP  = 3;
    localparam int PATH_BOOST  = 4;

    // Map a sequencer state to its one-hot path select (zero in a gap).
    function automatic logic [PATH_N-1:0] path_of(input seq_state_t st);
        logic [PATH_N-1:0] p;
        p = '0;
        case (st)
            ST_FREE:   p[PATH_FREE]   = 1'b1;
            ST_BUCK:   p[PATH_BUCK]   = 1'b1;
            ST_DIRECT: p[PATH_DIRECT] = 1'b1;
            ST_TOPUP:  p[PATH_TOPUP]  = 1'b1;
            ST_BOOST:  p[PATH_BOOST]  = 1'b1;
            default:   p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/simo_cyc_edge.sv
// Module: edge detector for the switching-cycle clock.
// Assumes cyc_clk is already synchronous to clk; produces one-clock rise and
// fall strobes relative to the value sampled at the previous edge.
module simo_cyc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_clk,
    output logic rise,
    output logic fall
);

    logic cyc_q;

    // Remember the cycle clock level of the previous controller edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= 1'b0;
        else        cyc_q <= cyc_clk;
    end

    // Compare present and previous level to find edges.
    always_comb begin
        rise = cyc_clk & ~cyc_q;
        fall = ~cyc_clk & cyc_q;
    end

endmodule

// File: rtl/simo_dead_timer.sv
// Module: dead-time gap counter.
// A load strobe starts a gap of len clocks; expire is high in the last clock
// of the gap. A len of zero is never loaded (the caller bypasses the gap).
module simo_dead_timer #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DT_W-1:0] len,
    output logic            expire
);

    logic [DT_W-1:0] cnt;

    // Load the gap length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - DT_W'(1);
    end

    // Flag the final clock of the gap.
    assign expire = (cnt == DT_W'(1));

endmodule

// File: rtl/simo_out_walker.sv
// Module: serves a group of outputs one after another in ascending index.
// While active, only the current output's enable is high; it moves on when
// that output's flag is sampled low. The index returns to zero whenever the
// group is inactive, so every phase begins at output 0.
module simo_out_walker #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [N-1:0] flags,
    output logic [N-1:0] en,
    output logic         done
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] idx;
    logic             cur_low;

    assign cur_low = ~flags[idx];

    // Advance the served index when the current output is satisfied.
    always_ff @(posedge clk) begin
        if (!rst_n)                          idx <= '0;
        else if (!active)                    idx <= '0;
        else if (cur_low && (idx != LAST))   idx <= idx + IDX_W'(1);
    end

    // Drive the single enable of the output being served.
    always_comb begin
        en = '0;
        if (active) en[idx] = 1'b1;
    end

    // Group finished once the last output's flag is low.
    assign done = active && (idx == LAST) && cur_low;

endmodule

// File: rtl/simo_path_seq.sv
// Module: top-level switching-path sequencer for a single-inductor,
// multi-output converter. Runs buck (or direct-supply), top-up, boost and
// freewheel phases once per cycle-clock period with dead-time gaps between
// paths. Assumes all flag inputs are synchronous to clk.
module simo_path_seq #(
    parameter int NUM_BUCK  = 2,
    parameter int NUM_BOOST = 2,
    parameter int DT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_clk,
    input  logic [NUM_BUCK-1:0]   buck_flag,
    input  logic [NUM_BOOST-1:0]  boost_flag,
    input  logic                  peak_trip,
    input  logic                  pwr_ok,
    input  logic [DT_W-1:0]       dead_len,
    output logic [4:0]            path_sel,
    output logic [NUM_BUCK-1:0]   buck_en,
    output logic [NUM_BOOST-1:0]  boost_en,
    output logic                  hyst_mode,
    output logic                  overrun
);

    import simo_seq_pkg::*;

    seq_state_t state, nstate, tgt, ntgt, want;
    logic       rise, fall, dead_exp, dead_load;
    logic       buck_done, boost_done, chg, abort, ovr_set, mode_load;
    logic       buck_act, boost_act;

    simo_cyc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_clk (cyc_clk),
        .rise    (rise),
        .fall    (fall)
    );

    simo_dead_timer #(.DT_W(DT_W)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (dead_load),
        .len    (dead_len),
        .expire (dead_exp)
    );

    assign buck_act  = (state == ST_BUCK) || (state == ST_DIRECT);
    assign boost_act = (state == ST_BOOST);

    simo_out_walker #(.N(NUM_BUCK)) u_buck_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (buck_act),
        .flags  (buck_flag),
        .en     (buck_en),
        .done   (buck_done)
    );

    simo_out_walker #(.N(NUM_BOOST)) u_boost_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (boost_act),
        .flags  (boost_flag),
        .en     (boost_en),
        .done   (boost_done)
    );

    // Abort applies to any live phase and to gaps leading into one.
    assign abort = fall && (buck_act || boost_act || (state == ST_TOPUP) ||
                            ((state == ST_DEAD) && (tgt != ST_FREE)));

    // Next-state decision: pick the wanted path, then route it via a gap.
    always_comb begin
        nstate    = state;
        ntgt      = tgt;
        want      = state;
        chg       = 1'b0;
        dead_load = 1'b0;
        ovr_set   = 1'b0;
        mode_load = 1'b0;
        case (state)
            ST_FREE: if (rise) begin
                want      = pwr_ok ? ST_BUCK : ST_DIRECT;
                chg       = 1'b1;
                mode_load = 1'b1;
            end
            ST_DEAD: if (dead_exp) nstate = tgt;
            ST_BUCK, ST_DIRECT: if (buck_done) begin
                want = peak_trip ? ST_BOOST : ST_TOPUP;
                chg  = 1'b1;
            end
            ST_TOPUP: if (peak_trip) begin
                want = ST_BOOST;
                chg  = 1'b1;
            end
            ST_BOOST: if (boost_done) begin
                want = ST_FREE;
                chg  = 1'b1;
            end
            default: nstate = ST_FREE;
        endcase
        if (abort) begin
            ovr_set = 1'b1;
            if (state == ST_DEAD) begin
                ntgt   = ST_FREE;
                nstate = dead_exp ? ST_FREE : ST_DEAD;
                chg    = 1'b0;
            end else begin
                want = ST_FREE;
                chg  = 1'b1;
            end
        end
        if (chg) begin
            if (dead_len == '0) begin
                nstate = want;
            end else begin
                nstate    = ST_DEAD;
                ntgt      = want;
                dead_load = 1'b1;
            end
        end
    end

    // Sequencer state, gap target, mode and sticky overrun registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FREE;
            tgt       <= ST_FREE;
            hyst_mode <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            state <= nstate;
            tgt   <= ntgt;
            if (mode_load) hyst_mode <= ~pwr_ok;
            if (ovr_set)   overrun   <= 1'b1;
        end
    end

    // Decode the registered state to the one-hot path select.
    assign path_sel = path_of(state);

endmodule

// File: rtl/simo_path_seq_chk.sv
// Module: property checker for the path sequencer, bound to the top module.
// Observes only ports; assumes the synchronous active-low reset.
module simo_path_seq_chk #(
    parameter int NUM_BUCK  = 2,
    parameter int NUM_BOOST = 2,
    parameter int DT_W      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DT_W-1:0]      dead_len,
    input logic [4:0]           path_sel,
    input logic [NUM_BUCK-1:0]  buck_en,
    input logic [NUM_BOOST-1:0] boost_en,
    input logic                 hyst_mode,
    input logic                 overrun
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (path_sel == 5'b00001 && buck_en == '0 && boost_en == '0 && !hyst_mode && !overrun)); // R1

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(path_sel)); // R8

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buck_en) && $onehot0(boost_en)); // R3

    AST_BUCK_EN_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (buck_en != '0) |-> (path_sel[1] || path_sel[2])); // R3

    AST_BOOST_EN_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_en != '0) |-> path_sel[4]); // R6

    AST_DIRECT_IN_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        path_sel[2] |-> hyst_mode); // R7

    AST_BUCK_IN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        path_sel[1] |-> !hyst_mode); // R7

    AST_NO_GAPLESS_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel != '0 && $past(path_sel) != '0 && path_sel != $past(path_sel))
        |-> ($past(dead_len) == '0)); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R10

endmodule

bind simo_path_seq simo_path_seq_chk #(
    .NUM_BUCK (NUM_BUCK),
    .NUM_BOOST(NUM_BOOST),
    .DT_W     (DT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dead_len (dead_len),
    .path_sel (path_sel),
    .buck_en  (buck_en),
    .boost_en (boost_en),
    .hyst_mode(hyst_mode),
    .overrun  (overrun)
);

// File: tb/sim_simo_path_seq.sv
`timescale 1ns/1ps
// Bench: scoreboard for the path sequencer. The driver changes inputs on the
// falling edge and queues the outputs expected after the next rising edge;
// the monitor pops and compares 1 ns after each rising edge.
module sim_simo_path_seq;

    localparam logic [4:0] P_FREE = 5'b00001;
    localparam logic [4:0] P_BUCK = 5'b00010;
    localparam logic [4:0] P_DIR  = 5'b00100;
    localparam logic [4:0] P_TOP  = 5'b01000;
    localparam logic [4:0] P_BST  = 5'b10000;
    localparam logic [4:0] P_GAP  = 5'b00000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_clk = 1'b0;
    logic [1:0] buck_flag = '0;
    logic [1:0] boost_flag = '0;
    logic       peak_trip = 1'b0;
    logic       pwr_ok = 1'b1;
    logic [3:0] dead_len = '0;
    logic [4:0] path_sel;
    logic [1:0] buck_en, boost_en;
    logic       hyst_mode, overrun;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    simo_path_seq #(.NUM_BUCK(2), .NUM_BOOST(2), .DT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_clk(cyc_clk),
        .buck_flag(buck_flag), .boost_flag(boost_flag),
        .peak_trip(peak_trip), .pwr_ok(pwr_ok), .dead_len(dead_len),
        .path_sel(path_sel), .buck_en(buck_en), .boost_en(boost_en),
        .hyst_mode(hyst_mode), .overrun(overrun)
    );

    // Monitor: compare each queued expectation just after a rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [10:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {path_sel, buck_en, boost_en, hyst_mode, overrun};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got path=%b buck=%b boost=%b hyst=%b ovr=%b, expected path=%b buck=%b boost=%b hyst=%b ovr=%b",
                         t, a[10:6], a[5:4], a[3:2], a[1], a[0],
                         e[10:6], e[5:4], e[3:2], e[1], e[0]);
            end
        end
    end

    // Driver: apply one clock of stimulus and queue the expected response.
    task automatic step(input logic r, input logic c, input logic [1:0] bf,
                        input logic [1:0] sf, input logic pk, input logic pok,
                        input logic [4:0] ep, input logic [1:0] eb,
                        input logic [1:0] es, input logic eh, input logic eo,
                        input string tag);
        @(negedge clk);
        rst_n = r; cyc_clk = c; buck_flag = bf; boost_flag = sf;
        peak_trip = pk; pwr_ok = pok;
        exp_q.push_back({ep, eb, es, eh, eo});
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        step(0,0,2'b00,2'b00,0,1, P_FREE,2'b00,2'b00,0,0, "R1 reset state");
        step(0,0,2'b00,2'b00,0,1, P_FREE,2'b00,2'b00,0,0, "R1 reset held");
        step(1,0,2'b00,2'b00,0,1, P_FREE,2'b00,2'b00,0,0, "R2 idle without edge");

        // Full PWM cycle with top-up, no dead time.
        step(1,1,2'b11,2'b11,0,1, P_BUCK,2'b01,2'b00,0,0, "R2 start into buck");
        step(1,1,2'b11,2'b11,0,1, P_BUCK,2'b01,2'b00,0,0, "R3 buck0 held");
        step(1,1,2'b10,2'b11,0,1, P_BUCK,2'b10,2'b00,0,0, "R3 hand to buck1");
        step(1,1,2'b00,2'b11,0,1, P_TOP ,2'b00,2'b00,0,0, "R4 enter top-up");
        step(1,1,2'b00,2'b11,0,1, P_TOP ,2'b00,2'b00,0,0, "R4 top-up held");
        step(1,1,2'b00,2'b11,1,1, P_BST ,2'b00,2'b01,0,0, "R6 boost0");
        step(1,1,2'b00,2'b10,1,1, P_BST ,2'b00,2'b10,0,0, "R6 boost1");
        step(1,1,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel");
        step(1,1,2'b11,2'b11,0,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel held");
        step(1,0,2'b11,2'b11,0,1, P_FREE,2'b00,2'b00,0,0, "R10 fall in freewheel");

        // Top-up skipped; flags already low give one clock each.
        step(1,1,2'b00,2'b11,1,1, P_BUCK,2'b01,2'b00,0,0, "R3 buck0 min one clock");
        step(1,1,2'b00,2'b11,1,1, P_BUCK,2'b10,2'b00,0,0, "R3 buck1");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b01,0,0, "R5 top-up skipped");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b10,0,0, "R6 boost1");
        step(1,1,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel");
        step(1,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel at fall");

        // Dead time of two clocks at every path change.
        dead_len = 4'd2;
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before buck 1");
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before buck 2");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b01,2'b00,0,0, "R9 buck after gap");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b10,2'b00,0,0, "R3 buck1 no gap");
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before boost 1");
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before boost 2");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b01,0,0, "R9 boost after gap");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b10,0,0, "R6 boost1");
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before free 1");
        step(1,1,2'b00,2'b00,1,1, P_GAP ,2'b00,2'b00,0,0, "R9 gap before free 2");
        step(1,1,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R9 free after gap");
        step(1,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R8 freewheel");
        dead_len = 4'd0;

        // Hysteresis mode, then return to PWM.
        step(1,1,2'b11,2'b11,0,0, P_DIR ,2'b01,2'b00,1,0, "R7 direct path");
        step(1,1,2'b10,2'b11,0,0, P_DIR ,2'b10,2'b00,1,0, "R7 direct buck1");
        step(1,1,2'b00,2'b11,0,0, P_TOP ,2'b00,2'b00,1,0, "R4 top-up in hyst");
        step(1,1,2'b00,2'b11,1,0, P_BST ,2'b00,2'b01,1,0, "R6 boost0 in hyst");
        step(1,1,2'b00,2'b00,1,0, P_BST ,2'b00,2'b10,1,0, "R6 boost1 in hyst");
        step(1,1,2'b00,2'b00,1,0, P_FREE,2'b00,2'b00,1,0, "R6 freewheel in hyst");
        step(1,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,1,0, "R7 mode held mid-period");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b01,2'b00,0,0, "R7 back to PWM");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b10,2'b00,0,0, "R3 buck1");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b01,0,0, "R5 skip top-up");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b10,0,0, "R6 boost1");
        step(1,1,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel");
        step(1,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R6 freewheel at fall");

        // Overrun: cycle clock falls during the buck phase.
        step(1,1,2'b11,2'b11,0,1, P_BUCK,2'b01,2'b00,0,0, "R2 start");
        step(1,1,2'b11,2'b11,0,1, P_BUCK,2'b01,2'b00,0,0, "R3 buck0 held");
        step(1,0,2'b11,2'b11,0,1, P_FREE,2'b00,2'b00,0,1, "R10 abort to freewheel");
        step(1,0,2'b11,2'b11,0,1, P_FREE,2'b00,2'b00,0,1, "R10 overrun sticky");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b01,2'b00,0,1, "R10 sticky next cycle");
        step(1,1,2'b00,2'b00,1,1, P_BUCK,2'b10,2'b00,0,1, "R3 buck1");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b01,0,1, "R5 skip top-up");
        step(1,1,2'b00,2'b00,1,1, P_BST ,2'b00,2'b10,0,1, "R6 boost1");
        step(1,1,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,1, "R10 still set");
        step(0,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R1 reset clears overrun");
        step(1,0,2'b00,2'b00,1,1, P_FREE,2'b00,2'b00,0,0, "R1 after reset");

        @(posedge clk); #2;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule